// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog

This block is a watchdog timer for a system-on-chip. A 12-bit down-counter advances once every prescaled tick, where the prescaler divides a slow timing enable (`tick_i`) by a power of two chosen by software. Software must service the watchdog by writing a refresh key to the key register. If the counter runs out, the block raises a one-cycle reset request. A refresh that comes too early also raises a reset request. A refresh is too early when the counter is still above a programmable window value.

All software access goes through a small 32-bit register bus with a write strobe, a word index and read data that is always valid. The three configuration registers (division code, reload value and window value) are write-protected. They accept writes only after an unlock key, and every other key closes them again.

Each accepted configuration write is staged first. It becomes the active value only after two prescaled ticks. While that delay runs, a per-register pending flag is visible in the status register. Once started, the watchdog cannot be stopped by any key.

Top module: `kww_watchdog`

## Requirements
- R1: After reset, the division code reads 0, the reload and window registers read 0xFFF, status reads 0, the watchdog is stopped and `rst_req_o` is low. Register word indices are: 0 key, 1 division code, 2 reload, 3 window, 4 status.
- R2: Writing the 32-bit word 0x0000CCCC to the key index starts the watchdog, loading the counter from the active reload value. No later key write stops it.
- R3: The key 0x00005555 opens the configuration registers. The key 0x00000000, the refresh key and any word that is not one of the four keys close them.
- R4: A write to index 1, 2 or 3 while the registers are closed has no effect on the read value or on the counter.
- R5: While running, the counter steps down once every 4<<code pulses of `tick_i` (codes 0..5 give 4..128; codes 6 and 7 both give 256). It does not move while `tick_i` is low.
- R6: When the counter is 0 at a prescaled tick, `rst_req_o` is raised and the counter reloads from the active reload value.
- R7: The refresh key 0x0000AAAA reloads the counter from the active reload value without a reset request in either of these cases:
  - the block is stopped;
  - the counter is at or below the active window value, or that value is 0xFFF.
- R8: The refresh key received while running, with a counter above an active window value other than 0xFFF, raises `rst_req_o` and leaves the counter unreloaded.
- R9: Status bits 0, 1 and 2 flag a pending division, reload and window update. Each is set on the edge of the accepted write. Each clears, at the same moment its staged value becomes active, on the second prescaled tick after that write.
- R10: Reads of indices 1 to 3 return the last accepted value at once, masked to 3 bits for the division code and 12 bits otherwise. Index 0 and unused indices read 0.
- R11: An accepted window write while running reloads the counter from the active reload value.
- R12: `rst_req_o` is a registered pulse. It is high for exactly the one cycle after the clock edge on which its cause (R6 or R8) was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow timing enable fed to the prescaler |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, a 3-bit division code and a two-tick update delay. It keeps reload values small, such as 20 and 2, so that timeouts, window hits and early refreshes happen within a few hundred cycles. With `tick_i` held high and code 0, a full count-down takes under a hundred cycles. Code 7 brings the 256 division within reach, checked against a bounded reset-request latency. A behavioural reference model tracks the counter, staged and active values and pending flags. Against it, `rst_req_o` is compared on every clock and every register read is compared.

// File: rtl/kww_pkg.sv
package kww_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [DATA_W-1:0] KEY_START = 32'h0000_CCCC;
  localparam logic [DATA_W-1:0] KEY_FEED  = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] KEY_OPEN  = 32'h0000_5555;
  localparam logic [DATA_W-1:0] KEY_SHUT  = 32'h0000_0000;

  typedef enum logic [ADDR_W-1:0] {
    IDX_KEY    = 3'd0,
    IDX_DIV    = 3'd1,
    IDX_RELOAD = 3'd2,
    IDX_WINDOW = 3'd3,
    IDX_STATUS = 3'd4
  } reg_idx_e;

  typedef enum logic [2:0] {
    KC_NONE,
    KC_START,
    KC_FEED,
    KC_OPEN,
    KC_SHUT,
    KC_OTHER
  } key_cmd_e;

  localparam int NUM_SLOTS   = 3;
  localparam int SLOT_DIV    = 0;
  localparam int SLOT_RELOAD = 1;
  localparam int SLOT_WINDOW = 2;

endpackage

// File: rtl/kww_prescaler.sv
module kww_prescaler #(
  parameter int CODE_W    = 3,
  parameter int MIN_SHIFT = 2,
  parameter int MAX_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ptick_o
);

  localparam int PRE_W = MAX_SHIFT;
  localparam int LIM_W = MAX_SHIFT + 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [LIM_W-1:0] limit;
  int               shift_amt;

  // divide ratio minus one, clamped at the largest ratio
  always_comb begin
    shift_amt = MIN_SHIFT + int'(code_i);
    if (shift_amt > MAX_SHIFT) shift_amt = MAX_SHIFT;
    limit = (LIM_W'(1) << shift_amt) - LIM_W'(1);
  end

  assign ptick_o = tick_i && ({1'b0, pre_q} >= limit);

  always_comb begin
    pre_d = pre_q;
    if (ptick_o)     pre_d = '0;
    else if (tick_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assert_wrap_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptick_o |=> (pre_q == '0));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pre_q));

endmodule

// File: rtl/kww_cfg_slot.sv
module kww_cfg_slot #(
  parameter int             W          = 12,
  parameter logic [W-1:0]   RESET_VAL  = '0,
  parameter int             SYNC_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ptick_i,
  output logic [W-1:0] staged_o,
  output logic [W-1:0] active_o,
  output logic         pending_o
);

  localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

  logic [W-1:0]      staged_q, staged_d;
  logic [W-1:0]      active_q, active_d;
  logic [SYNC_W-1:0] wait_q, wait_d;

  always_comb begin
    staged_d = staged_q;
    active_d = active_q;
    wait_d   = wait_q;
    if (wr_i) begin
      staged_d = wdata_i;
      wait_d   = SYNC_W'(SYNC_TICKS);
    end else if (ptick_i && (wait_q != '0)) begin
      wait_d = wait_q - 1'b1;
      if (wait_q == SYNC_W'(1)) active_d = staged_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= RESET_VAL;
      active_q <= RESET_VAL;
      wait_q   <= '0;
    end else begin
      staged_q <= staged_d;
      active_q <= active_d;
      wait_q   <= wait_d;
    end
  end

  assign staged_o  = staged_q;
  assign active_o  = active_q;
  assign pending_o = (wait_q != '0);

  assert_pending_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (pending_o && staged_o == $past(wdata_i)));

  assert_active_moves_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ptick_i |=> $stable(active_q));

  assert_clear_applies_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending_o) |-> (active_o == staged_o));

endmodule

// File: rtl/kww_counter.sv
module kww_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running_i,
  input  logic             ptick_i,
  input  logic             load_i,
  input  logic             early_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             req_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  always_comb begin
    cnt_d = cnt_q;
    req_d = early_i;
    if (load_i) begin
      cnt_d = reload_i;
    end else if (running_i && ptick_i) begin
      if (cnt_q == '0) begin
        cnt_d = reload_i;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running_i && ptick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_zero_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running_i && ptick_i && !load_i && cnt_q == '0) |=> (req_o && cnt_q == $past(reload_i)));

  assert_early_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    early_i |=> req_o);

  assert_stopped_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_i && !early_i) |=> !req_o);

endmodule

// File: rtl/kww_watchdog.sv
module kww_watchdog
  import kww_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int CODE_W     = 3,
  parameter int MIN_SHIFT  = 2,
  parameter int MAX_SHIFT  = 8,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o
);

  localparam logic [CNT_W-1:0] WIN_OFF = {CNT_W{1'b1}};

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // key decode
  logic     key_wr;
  key_cmd_e key_cmd;

  assign key_wr = bus_we_i && (bus_addr_i == IDX_KEY);

  always_comb begin
    key_cmd = KC_NONE;
    if (key_wr) begin
      case (bus_wdata_i)
        KEY_START: key_cmd = KC_START;
        KEY_FEED:  key_cmd = KC_FEED;
        KEY_OPEN:  key_cmd = KC_OPEN;
        KEY_SHUT:  key_cmd = KC_SHUT;
        default:   key_cmd = KC_OTHER;
      endcase
    end
  end

  logic running_q, running_d;
  logic unlocked_q, unlocked_d;

  always_comb begin
    running_d  = running_q | (key_cmd == KC_START);
    unlocked_d = unlocked_q;
    case (key_cmd)
      KC_OPEN:                    unlocked_d = 1'b1;
      KC_SHUT, KC_FEED, KC_OTHER: unlocked_d = 1'b0;
      default:                    unlocked_d = unlocked_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      running_q  <= 1'b0;
      unlocked_q <= 1'b0;
    end else begin
      running_q  <= running_d;
      unlocked_q <= unlocked_d;
    end
  end

  // configuration slots
  logic                 ptick;
  logic [NUM_SLOTS-1:0] slot_wr;
  logic [NUM_SLOTS-1:0] slot_pend;
  logic [CNT_W-1:0]     slot_staged [NUM_SLOTS];
  logic [CODE_W-1:0]    act_code;
  logic [CNT_W-1:0]     act_reload;
  logic [CNT_W-1:0]     act_window;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int                SW = (g == SLOT_DIV) ? CODE_W : CNT_W;
    localparam logic [SW-1:0]     RV = (g == SLOT_DIV) ? {SW{1'b0}} : {SW{1'b1}};
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(int'(IDX_DIV) + g);

    logic [SW-1:0] st;
    logic [SW-1:0] ac;

    assign slot_wr[g] = bus_we_i && unlocked_q && (bus_addr_i == SA);

    kww_cfg_slot #(
      .W          (SW),
      .RESET_VAL  (RV),
      .SYNC_TICKS (SYNC_TICKS)
    ) i_slot (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_i      (slot_wr[g]),
      .wdata_i   (bus_wdata_i[SW-1:0]),
      .ptick_i   (ptick),
      .staged_o  (st),
      .active_o  (ac),
      .pending_o (slot_pend[g])
    );

    assign slot_staged[g] = CNT_W'(st);

    if (g == SLOT_DIV) begin : g_code
      assign act_code = ac;
    end else if (g == SLOT_RELOAD) begin : g_reload
      assign act_reload = ac;
    end else begin : g_window
      assign act_window = ac;
    end
  end

  kww_prescaler #(
    .CODE_W    (CODE_W),
    .MIN_SHIFT (MIN_SHIFT),
    .MAX_SHIFT (MAX_SHIFT)
  ) i_prescaler (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (tick_i),
    .code_i  (act_code),
    .ptick_o (ptick)
  );

  // refresh window decision
  logic [CNT_W-1:0] cnt;
  logic             feed_ok;
  logic             early;
  logic             load;

  always_comb begin
    feed_ok = 1'b0;
    early   = 1'b0;
    if (key_cmd == KC_FEED) begin
      if (!running_q || act_window == WIN_OFF || cnt <= act_window) feed_ok = 1'b1;
      else                                                         early   = 1'b1;
    end
    load = feed_ok
         || (key_cmd == KC_START && !running_q)
         || (slot_wr[SLOT_WINDOW] && running_q);
  end

  kww_counter #(
    .CNT_W (CNT_W)
  ) i_counter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .running_i (running_q),
    .ptick_i   (ptick),
    .load_i    (load),
    .early_i   (early),
    .reload_i  (act_reload),
    .cnt_o     (cnt),
    .req_o     (rst_req_o)
  );

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      IDX_DIV:    bus_rdata_o = DATA_W'(slot_staged[SLOT_DIV]);
      IDX_RELOAD: bus_rdata_o = DATA_W'(slot_staged[SLOT_RELOAD]);
      IDX_WINDOW: bus_rdata_o = DATA_W'(slot_staged[SLOT_WINDOW]);
      IDX_STATUS: bus_rdata_o = DATA_W'(slot_pend);
      default:    bus_rdata_o = '0;
    endcase
  end

  assert_running_sticky_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    running_q |=> running_q);

  assert_bad_key_locks_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (key_cmd == KC_OTHER) |=> !unlocked_q);

  assert_locked_reload_held_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we_i && !unlocked_q && bus_addr_i == IDX_RELOAD) |=> $stable(slot_staged[SLOT_RELOAD]));

  assert_window_write_reload_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (slot_wr[SLOT_WINDOW] && running_q) |=> (cnt == $past(act_reload)));

endmodule

// File: tb/test_kww_watchdog.sv
module test_kww_watchdog;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int req_count = 0;
  bit started = 1'b0;

  always #10 clk = ~clk;

  kww_watchdog i_kww_watchdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .rst_req_o   (rst_req)
  );

  // behavioural reference model
  int m_pre, m_cnt;
  int m_act [3];
  int m_stg [3];
  int m_pend [3];
  bit m_run, m_unl, m_req;
  int t_div, t_idx;
  bit t_pt, t_ld, t_ev;
  bit t_wr [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 4095; m_run = 0; m_unl = 0; m_req = 0;
      m_act = '{0, 4095, 4095};
      m_stg = '{0, 4095, 4095};
      m_pend = '{0, 0, 0};
    end else begin
      t_div = 4 << ((m_act[0] > 6) ? 6 : m_act[0]);
      t_pt = tick && (m_pre >= t_div - 1);
      t_ld = 0; t_ev = 0;
      t_wr = '{0, 0, 0};
      if (we) begin
        if (addr == 3'd0) begin
          if (wdata == 32'hCCCC) begin
            if (!m_run) begin m_run = 1; m_cnt = m_act[1]; t_ld = 1; end
          end else if (wdata == 32'hAAAA) begin
            m_unl = 0;
            if (m_run && m_act[2] != 4095 && m_cnt > m_act[2]) t_ev = 1;
            else begin m_cnt = m_act[1]; t_ld = 1; end
          end else if (wdata == 32'h5555) m_unl = 1;
          else m_unl = 0;
        end else if (addr >= 3'd1 && addr <= 3'd3 && m_unl) begin
          t_idx = int'(addr) - 1;
          t_wr[t_idx] = 1;
          m_stg[t_idx] = int'(wdata & ((t_idx == 0) ? 32'h7 : 32'hFFF));
          m_pend[t_idx] = 2;
          if (t_idx == 2 && m_run) begin m_cnt = m_act[1]; t_ld = 1; end
        end
      end
      if (!t_ld && m_run && t_pt) begin
        if (m_cnt == 0) begin t_ev = 1; m_cnt = m_act[1]; end
        else m_cnt = m_cnt - 1;
      end
      for (int i = 0; i < 3; i++) begin
        if (!t_wr[i] && t_pt && m_pend[i] > 0) begin
          m_pend[i] = m_pend[i] - 1;
          if (m_pend[i] == 0) m_act[i] = m_stg[i];
        end
      end
      m_pre = t_pt ? 0 : (tick ? m_pre + 1 : m_pre);
      m_req = t_ev;
    end
  end

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd1: return 32'(m_stg[0]);
      3'd2: return 32'(m_stg[1]);
      3'd3: return 32'(m_stg[2]);
      3'd4: return {29'd0, m_pend[2] != 0, m_pend[1] != 0, m_pend[0] != 0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle compare of the reset request (R6 R8 R12)
  always @(negedge clk) begin
    if (started) begin
      check("R12 R6 R8 rst_req vs model", {31'd0, rst_req}, {31'd0, m_req});
      if (rst_req) req_count++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
    check({tag, " model"}, rdata, model_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    finish_run();
  end

  int base;
  int lat;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(6);
    started = 1'b1;

    // R1 reset state
    rd(3'd1, 32'h0, "R1 division code after reset");
    rd(3'd2, 32'hFFF, "R1 reload after reset");
    rd(3'd3, 32'hFFF, "R1 window after reset");
    rd(3'd4, 32'h0, "R1 status after reset");
    check("R1 rst_req after reset", {31'd0, rst_req}, 32'd0);
    tick = 1'b1;

    // R4 locked write ignored
    wr(3'd2, 32'd20);
    rd(3'd2, 32'hFFF, "R4 locked reload write");
    rd(3'd4, 32'h0, "R4 no pending after locked write");

    // R3 unlock, R10 readback and masking, R9 pending flag
    wr(3'd0, 32'h5555);
    wr(3'd2, 32'h1234);
    rd(3'd2, 32'h234, "R10 reload masked to 12 bits");
    rd(3'd4, 32'h2, "R9 reload pending set");
    wr(3'd1, 32'hF8);
    rd(3'd1, 32'h0, "R10 division code masked to 3 bits");
    wr(3'd2, 32'd20);
    rd(3'd2, 32'd20, "R10 reload readback");
    idle(12);
    rd(3'd4, 32'h0, "R9 pending cleared after two ticks");
    rd(3'd0, 32'h0, "R10 key index reads zero");

    // R3 undefined key relocks
    wr(3'd0, 32'h1234);
    wr(3'd2, 32'd50);
    rd(3'd2, 32'd20, "R3 undefined key relocks");
    wr(3'd0, 32'h5555);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'd50);
    rd(3'd2, 32'd20, "R3 zero key relocks");

    // R2 start and R6 timeout
    base = req_count;
    wr(3'd0, 32'hCCCC);
    idle(100);
    check("R6 one timeout after start", 32'(req_count - base), 32'd1);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'hCCCC);
    base = req_count;
    idle(100);
    check("R2 still running after stop attempts", 32'(req_count > base), 32'd1);

    // R11 window write reloads, R8 early refresh
    wr(3'd0, 32'h5555);
    wr(3'd3, 32'd10);
    idle(10);
    rd(3'd3, 32'd10, "R10 window readback");
    check("R8 precondition counter above window", 32'(m_cnt > 10), 32'd1);
    base = req_count;
    wr(3'd0, 32'hAAAA);
    idle(2);
    check("R8 early refresh requests reset", 32'(req_count - base), 32'd1);

    // R7 refresh inside window
    while (!(m_cnt <= 10 && m_cnt > 5)) @(negedge clk);
    base = req_count;
    wr(3'd0, 32'hAAAA);
    idle(40);
    check("R7 refresh inside window no request", 32'(req_count - base), 32'd0);

    // R11 window write while running reloads counter
    while (m_cnt > 2) @(negedge clk);
    wr(3'd0, 32'h5555);
    base = req_count;
    wr(3'd3, 32'd10);
    idle(60);
    check("R11 window write reloads counter", 32'(req_count - base), 32'd0);

    // R5 division code 7 gives 256
    wr(3'd0, 32'h5555);
    wr(3'd3, 32'hFFF);
    wr(3'd2, 32'd2);
    wr(3'd1, 32'd7);
    idle(20);
    rd(3'd4, 32'h0, "R9 all updates applied");
    wr(3'd0, 32'hAAAA);
    lat = 0;
    while (!rst_req && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    check("R5 code 7 latency within 256 range", 32'(lat >= 513 && lat <= 768), 32'd1);

    // R5 no count while tick low
    wr(3'd0, 32'hAAAA);
    tick = 1'b0;
    base = req_count;
    idle(1000);
    check("R5 counter frozen without tick", 32'(req_count - base), 32'd0);
    tick = 1'b1;
    idle(900);
    check("R5 counter resumes with tick", 32'(req_count > base), 32'd1);

    idle(4);
    finish_run();
  end

endmodule